// File: doc/BRIEF.md
# Dual-Channel PCM Serial Receiver

This block receives 8-bit voice samples on the receive side of a two-channel codec. It watches a bit clock, a frame sync and two serial data lines. All of them are brought into a free-running system clock domain through synchronizers, and the block acts on the edges it detects there. Each received sample goes into a parallel output register for its channel, and a one-cycle strobe marks every update.

Two lane arrangements are available, chosen by a static mode input:

- **Split mode:** each data line carries its own channel, and both lines share the same frame sync.
- **Shared mode:** the first data line is not used. The second line carries channel 1 in the first eight bit slots after the sync and channel 2 in the next eight.

The block also has a power-save indication. A bit clock that is parked high or parked low is treated as a request to power down. When no bit-clock edge arrives for a set number of system cycles, the power-save flag rises. The next edge clears it, and the receiver then waits for a fresh frame sync before it captures anything.

Top module: `pcm_dual_rx`

## Requirements
- R1: After reset both sample registers read 0, both strobes are low and the power-save flag is low.
- R2: In split mode (`lane_shared`=0), bits are taken on falling bit-clock edges, most significant first. On the eighth bit after a sync rise, `ch1_data` loads from `din_a` and `ch2_data` loads from `din_b`, and both strobes pulse in the same cycle.
- R3: In shared mode (`lane_shared`=1), the first eight bits on `din_b` after a sync rise load into `ch1_data` and the following eight load into `ch2_data`, each with its own strobe. `din_a` has no effect on either output.
- R4: Bits that arrive after the frame is complete are not captured until the next sync rise. A frame is complete after eight bits in split mode and sixteen in shared mode. Bits that arrive before any sync are not captured either.
- R5: A sync rise in the middle of a frame restarts the frame. The next falling edge then supplies the most significant bit.
- R6: Each strobe is high for exactly one system cycle. A sample register changes only in a cycle where its strobe is high.
- R7: `pwr_save` rises once the bit clock has shown no edge for `IDLE_LIMIT` system cycles. This holds whether the clock is parked high or parked low.
- R8: The first bit-clock edge after a stall clears `pwr_save`. A frame that was partly received before the stall is dropped, and nothing is captured until a new sync rise.
- R9: No strobe is raised while `pwr_save` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_shared | input | 1 | 0: split lanes, 1: both channels on `din_b` (static) |
| bclk | input | 1 | Serial bit clock, asynchronous to `clk` |
| fsync | input | 1 | Receive frame sync; its rising edge marks the first bit |
| din_a | input | 1 | Serial data, channel 1 in split mode |
| din_b | input | 1 | Serial data, channel 2 in split mode, both channels in shared mode |
| ch1_data | output | SAMPLE_W | Channel 1 sample register |
| ch1_valid | output | 1 | One-cycle strobe on channel 1 update |
| ch2_data | output | SAMPLE_W | Channel 2 sample register |
| ch2_valid | output | 1 | One-cycle strobe on channel 2 update |
| pwr_save | output | 1 | Bit clock has stalled; receive path is asleep |

## Verification
The checker assumes the following about the inputs:

- `lane_shared` stays constant while frames are in flight.
- Each high and low phase of the bit clock lasts several system cycles.
- Data and sync change only on the rising bit-clock edge, so they are settled when the falling edge is seen.

The bench keeps within these limits. It holds each bit-clock phase for four system cycles, drives data and sync together with the rising edge, and changes the mode only between sweeps while the bit clock is idle. Under these conditions the pairing and ordering of strobes in each mode, and the absence of strobes during power save, can be stated as plain cycle properties.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

   typedef enum logic {
      LANE_SPLIT  = 1'b0,
      LANE_SHARED = 1'b1
   } lane_mode_e;

   localparam int MIN_SYNC_STAGES = 2;
   localparam int MIN_SAMPLE_W    = 2;
   localparam int MIN_IDLE_LIMIT  = 4;

endpackage

// File: rtl/pcm_bit_sync.sv
module pcm_bit_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pcm_bclk_watch.sv
module pcm_bclk_watch #(
   parameter int IDLE_LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_s,
   output logic bit_fall,
   output logic asleep
);

   localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);
   localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(IDLE_LIMIT);

   logic              bclk_prev;
   logic              any_edge;
   logic [IDLE_W-1:0] idle_cnt;

   assign any_edge = bclk_prev ^ bclk_s;
   assign bit_fall = bclk_prev & ~bclk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_prev <= 1'b0;
         idle_cnt  <= '0;
         asleep    <= 1'b0;
      end else begin
         bclk_prev <= bclk_s;
         if (any_edge) begin
            idle_cnt <= '0;
            asleep   <= 1'b0;
         end else if (idle_cnt == IDLE_MAX) begin
            asleep   <= 1'b1;
         end else begin
            idle_cnt <= idle_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pcm_frame_deser.sv
module pcm_frame_deser
   import pcm_rx_pkg::*;
#(
   parameter int SAMPLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lane_shared,
   input  logic                asleep,
   input  logic                bit_fall,
   input  logic                fs_s,
   input  logic                din_a_s,
   input  logic                din_b_s,
   output logic [SAMPLE_W-1:0] ch1_q,
   output logic                ch1_stb,
   output logic [SAMPLE_W-1:0] ch2_q,
   output logic                ch2_stb
);

   localparam int FRAME_BITS = 2 * SAMPLE_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] CNT_SPLIT  = CNT_W'(SAMPLE_W);
   localparam logic [CNT_W-1:0] CNT_SHARED = CNT_W'(FRAME_BITS);

   lane_mode_e          mode;
   logic [CNT_W-1:0]    bit_cnt, cnt_nxt, cnt_lim;
   logic                fs_prev, start_pend, fs_rise, start_now, in_frame;
   logic [SAMPLE_W-1:0] sh_a, sh_b, sh_a_nxt, sh_b_nxt;

   assign mode      = lane_mode_e'(lane_shared);
   assign cnt_lim   = (mode == LANE_SHARED) ? CNT_SHARED : CNT_SPLIT;
   assign fs_rise   = fs_s & ~fs_prev;
   assign start_now = start_pend | fs_rise;
   assign in_frame  = start_now | (bit_cnt < cnt_lim);
   assign sh_a_nxt  = {sh_a[SAMPLE_W-2:0], din_a_s};
   assign sh_b_nxt  = {sh_b[SAMPLE_W-2:0], din_b_s};
   assign cnt_nxt   = start_now ? CNT_W'(1) : bit_cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt    <= CNT_SHARED;
         fs_prev    <= 1'b0;
         start_pend <= 1'b0;
         sh_a       <= '0;
         sh_b       <= '0;
         ch1_q      <= '0;
         ch2_q      <= '0;
         ch1_stb    <= 1'b0;
         ch2_stb    <= 1'b0;
      end else begin
         fs_prev <= fs_s;
         ch1_stb <= 1'b0;
         ch2_stb <= 1'b0;
         if (asleep) begin
            // drop any partial frame; wait for a fresh sync after wake
            bit_cnt    <= CNT_SHARED;
            start_pend <= 1'b0;
         end else if (bit_fall && in_frame) begin
            start_pend <= 1'b0;
            bit_cnt    <= cnt_nxt;
            sh_a       <= sh_a_nxt;
            sh_b       <= sh_b_nxt;
            if (cnt_nxt == CNT_SPLIT) begin
               ch1_q   <= (mode == LANE_SHARED) ? sh_b_nxt : sh_a_nxt;
               ch1_stb <= 1'b1;
               if (mode == LANE_SPLIT) begin
                  ch2_q   <= sh_b_nxt;
                  ch2_stb <= 1'b1;
               end
            end
            if (mode == LANE_SHARED && cnt_nxt == CNT_SHARED) begin
               ch2_q   <= sh_b_nxt;
               ch2_stb <= 1'b1;
            end
         end else if (fs_rise) begin
            start_pend <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/pcm_dual_rx.sv
module pcm_dual_rx
   import pcm_rx_pkg::*;
#(
   parameter int SAMPLE_W    = 8,
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_LIMIT  = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lane_shared,
   input  logic                bclk,
   input  logic                fsync,
   input  logic                din_a,
   input  logic                din_b,
   output logic [SAMPLE_W-1:0] ch1_data,
   output logic                ch1_valid,
   output logic [SAMPLE_W-1:0] ch2_data,
   output logic                ch2_valid,
   output logic                pwr_save
);

   localparam int N_LINES = 4;

   if (SAMPLE_W < MIN_SAMPLE_W) begin : g_bad_width
      $error("pcm_dual_rx: SAMPLE_W must be at least %0d", MIN_SAMPLE_W);
   end
   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("pcm_dual_rx: SYNC_STAGES must be at least %0d", MIN_SYNC_STAGES);
   end
   if (IDLE_LIMIT < MIN_IDLE_LIMIT) begin : g_bad_idle
      $error("pcm_dual_rx: IDLE_LIMIT must be at least %0d", MIN_IDLE_LIMIT);
   end

   logic [N_LINES-1:0] raw_lines, sync_lines;
   logic               bit_fall, asleep;

   assign raw_lines = {bclk, fsync, din_a, din_b};

   pcm_bit_sync #(
      .WIDTH  (N_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_lines),
      .q     (sync_lines)
   );

   pcm_bclk_watch #(
      .IDLE_LIMIT (IDLE_LIMIT)
   ) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk_s   (sync_lines[3]),
      .bit_fall (bit_fall),
      .asleep   (asleep)
   );

   pcm_frame_deser #(
      .SAMPLE_W (SAMPLE_W)
   ) u_deser (
      .clk         (clk),
      .rst_n       (rst_n),
      .lane_shared (lane_shared),
      .asleep      (asleep),
      .bit_fall    (bit_fall),
      .fs_s        (sync_lines[2]),
      .din_a_s     (sync_lines[1]),
      .din_b_s     (sync_lines[0]),
      .ch1_q       (ch1_data),
      .ch1_stb     (ch1_valid),
      .ch2_q       (ch2_data),
      .ch2_stb     (ch2_valid)
   );

   assign pwr_save = asleep;

endmodule

// File: rtl/pcm_dual_rx_chk.sv
module pcm_dual_rx_chk #(
   parameter int SAMPLE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                lane_shared,
   input logic [SAMPLE_W-1:0] ch1_data,
   input logic                ch1_valid,
   input logic [SAMPLE_W-1:0] ch2_data,
   input logic                ch2_valid,
   input logic                pwr_save
);

   AST_CH1_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ch1_valid |=> !ch1_valid); // R6
   AST_CH2_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ch2_valid |=> !ch2_valid); // R6
   AST_CH1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ch1_data) |-> ch1_valid); // R6
   AST_CH2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ch2_data) |-> ch2_valid); // R6
   AST_SPLIT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (!lane_shared && ch1_valid) |-> ch2_valid); // R2
   AST_SHARED_APART: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_shared && ch2_valid) |-> !ch1_valid); // R3
   AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_save |-> (!ch1_valid && !ch2_valid)); // R9

endmodule

bind pcm_dual_rx pcm_dual_rx_chk #(
   .SAMPLE_W (SAMPLE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lane_shared (lane_shared),
   .ch1_data    (ch1_data),
   .ch1_valid   (ch1_valid),
   .ch2_data    (ch2_data),
   .ch2_valid   (ch2_valid),
   .pwr_save    (pwr_save)
);

// File: tb/tb_pcm_dual_rx.sv
module tb_pcm_dual_rx;

   localparam int SW   = 8;
   localparam int IDLE = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lane_shared = 1'b0;
   logic          bclk = 1'b0, fsync = 1'b0, din_a = 1'b0, din_b = 1'b0;
   logic [SW-1:0] ch1_data, ch2_data;
   logic          ch1_valid, ch2_valid, pwr_save;

   int n_tests = 0, n_fail = 0;
   int n1 = 0, n2 = 0, hold_err = 0, pulse_err = 0, sleep_err = 0;
   logic [SW-1:0] last1 = '0, last2 = '0, prev1 = '0, prev2 = '0;
   logic          pv1 = 1'b0, pv2 = 1'b0;
   bit            done = 1'b0;

   always #10 clk = ~clk;

   pcm_dual_rx #(.SAMPLE_W(SW), .SYNC_STAGES(2), .IDLE_LIMIT(IDLE)) dut (
      .clk(clk), .rst_n(rst_n), .lane_shared(lane_shared), .bclk(bclk),
      .fsync(fsync), .din_a(din_a), .din_b(din_b),
      .ch1_data(ch1_data), .ch1_valid(ch1_valid),
      .ch2_data(ch2_data), .ch2_valid(ch2_valid), .pwr_save(pwr_save));

   // output monitor, sampled on the falling system-clock edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (ch1_valid) begin n1++; last1 = ch1_data; end
         if (ch2_valid) begin n2++; last2 = ch2_data; end
         if (!ch1_valid && ch1_data != prev1) hold_err++;
         if (!ch2_valid && ch2_data != prev2) hold_err++;
         if ((ch1_valid && pv1) || (ch2_valid && pv2)) pulse_err++;
         if (pwr_save && (ch1_valid || ch2_valid)) sleep_err++;
      end
      prev1 = ch1_data; prev2 = ch2_data;
      pv1 = ch1_valid;  pv2 = ch2_valid;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bit_cycle(input logic a, input logic b, input logic fs);
      bclk = 1'b1; din_a = a; din_b = b; fsync = fs;
      repeat (4) @(negedge clk);
      bclk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic frame_split(input logic [SW-1:0] v1, input logic [SW-1:0] v2);
      int c1 = n1, c2 = n2;
      for (int i = 0; i < SW; i++) bit_cycle(v1[SW-1-i], v2[SW-1-i], i == 0);
      for (int i = 0; i < 3; i++) bit_cycle(~v2[i], v1[i], 1'b0); // trailing junk, R4
      check(n1 - c1 == 1 && n2 - c2 == 1, "R2/R4 strobe count", n1 - c1, 1);
      check(last1 == v1, "R2 ch1 value", last1, v1);
      check(last2 == v2, "R2 ch2 value", last2, v2);
   endtask

   task automatic frame_shared(input logic [SW-1:0] v1, input logic [SW-1:0] v2,
                               input logic [2*SW-1:0] junk_a);
      int c1 = n1, c2 = n2;
      logic [2*SW-1:0] word = {v1, v2};
      for (int i = 0; i < 2*SW; i++) bit_cycle(junk_a[i], word[2*SW-1-i], i == 0);
      for (int i = 0; i < 3; i++) bit_cycle(junk_a[i], ~v1[i], 1'b0); // R4
      check(n1 - c1 == 1 && n2 - c2 == 1, "R3/R4 strobe count", n1 - c1, 1);
      check(last1 == v1, "R3 ch1 value", last1, v1);
      check(last2 == v2, "R3 ch2 value", last2, v2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int c;
      repeat (3) @(negedge clk);
      check(ch1_data == 0 && ch2_data == 0, "R1 data after reset", ch1_data, 0);
      check(!ch1_valid && !ch2_valid && !pwr_save, "R1 flags after reset",
            {ch1_valid, ch2_valid, pwr_save}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R4: bits with no sync yet are not captured
      c = n1;
      for (int i = 0; i < 10; i++) bit_cycle(1'b1, 1'b1, 1'b0);
      check(n1 == c && ch1_data == 0, "R4 no capture before sync", n1 - c, 0);

      // R2: full sweep of channel-1 values in split mode
      for (int v = 0; v < 256; v++)
         frame_split(SW'(v), SW'(v * 37 + 11));

      // R5: partial frame then a new sync restarts
      c = n1;
      for (int i = 0; i < 5; i++) bit_cycle(1'b1, 1'b0, i == 0);
      frame_split(8'h3C, 8'hC5);
      check(n1 - c == 1, "R5 restart strobe count", n1 - c, 1);

      // R7: bclk parked high
      bclk = 1'b1;
      repeat (IDLE - 10) @(negedge clk);
      check(pwr_save == 1'b0, "R7 not asleep early", pwr_save, 0);
      repeat (30) @(negedge clk);
      check(pwr_save == 1'b1, "R7 asleep, bclk high", pwr_save, 1);
      bclk = 1'b0;
      repeat (4) @(negedge clk);
      check(pwr_save == 1'b0, "R8 wake on edge", pwr_save, 0);

      // R8: frame interrupted by a low stall is dropped
      c = n1;
      for (int i = 0; i < 4; i++) bit_cycle(1'b1, 1'b1, i == 0);
      repeat (IDLE + 20) @(negedge clk);
      check(pwr_save == 1'b1, "R7 asleep, bclk low", pwr_save, 1);
      for (int i = 0; i < 12; i++) bit_cycle(1'b0, 1'b1, 1'b0);
      check(pwr_save == 1'b0, "R8 awake after edges", pwr_save, 0);
      check(n1 == c && last1 == 8'h3C, "R8 no capture after wake", last1, 8'h3C);
      frame_split(8'hA7, 8'h19);

      // R3: shared mode sweep with junk on din_a
      lane_shared = 1'b1;
      repeat (4) @(negedge clk);
      for (int v = 0; v < 256; v++)
         frame_shared(SW'(v), SW'((v ^ 8'hA5) + 3), 16'(~(v * 73)));

      check(hold_err == 0, "R6 data held between strobes", hold_err, 0);
      check(pulse_err == 0, "R6 single-cycle strobe", pulse_err, 0);
      check(sleep_err == 0, "R9 no strobe while asleep", sleep_err, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule